// File: doc/BRIEF.md
# Four-Way Bus Grant Arbiter

This block decides which of four requesters owns a shared bus. Requester 0 is the processor's internal request. Requesters 1 to 3 are external bus masters. Each requester raises its bit of `req_i`. The arbiter answers with a registered one-hot grant on `gnt_o`.

A two-bit policy input picks one of four policies: strict priority, full rotation, hybrid, or ping-pong. In hybrid the processor always comes first and the three external masters rotate among themselves. In ping-pong, turns alternate between the processor and the external masters.

Two timers protect the bus:
- A retry mask shuts a retried master out of arbitration for a fixed number of cycles.
- A dead-master timer takes the grant back from a master that keeps requesting but never drives the bus busy.

While the owner holds the lock, its grant is frozen. When nobody is eligible, the grant parks on the processor.

Top module: `pci_bus_arbiter`

## Requirements
- R1: `gnt_o` never has more than one bit set, and it is 4'b0000 while `rst` is high. Bit 0 is the processor, and bits 1, 2 and 3 are external masters 0, 1 and 2.
- R2: With `mode_i` = 2'b00 the winner is the lowest-numbered eligible requester (processor, then masters 0, 1, 2).
- R3: With `mode_i` = 2'b01 the search for a winner starts at the requester one above the last one granted, wrapping from 3 back to 0. After reset the last grant counts as requester 3.
- R4: With `mode_i` = 2'b10 an eligible processor request always wins. Otherwise the external masters are searched starting one above the last external master granted, wrapping from 3 to 1. After reset the last external grant counts as requester 3.
- R5: With `mode_i` = 2'b11, if the last grant went to the processor, the external masters are searched first (in the round-robin order of R4) and the processor comes second. If the last grant went to an external master, the processor comes first.
- R6: A grant is issued one clock edge after the cycle in which the arbiter had no grant. While a grant is held and the lock is not, the grant is dropped to all-zero on an edge where `idle_i` is high and the policy's winner differs from the owner. A held grant never moves directly to a different requester. It is never dropped while `idle_i` is low unless `retry_i` is high.
- R7: When no requester is eligible, the grant goes to the processor (4'b0001).
- R8: `retry_i` high while a grant is held and the lock is not drops the grant on the next edge. The owner is then excluded from arbitration for RETRY_CYCLES cycles.
- R9: If the owner keeps its request high while `idle_i` stays high for DEAD_CYCLES consecutive cycles (lock low), the grant is dropped on the last of those edges. The owner is then excluded for RETRY_CYCLES cycles.
- R10: While a grant is held and `lock_i` is high, the grant does not change, whatever `req_i`, `idle_i` or `retry_i` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy: 00 fixed, 01 rotating, 10 hybrid, 11 ping-pong |
| req_i | input | 4 | Requests; bit 0 processor, bits 1..3 external masters |
| idle_i | input | 1 | Bus idle (high) or a transaction in progress (low) |
| lock_i | input | 1 | Current owner holds the system lock |
| retry_i | input | 1 | Current owner's transaction was retried by its target |
| gnt_o | output | 4 | One-hot grant |

## Verification
The bench drives the gap cycle on a grant change. A design that hands the bus straight from one master to another would show two different grants on back-to-back cycles.

It counts the dead timer to the exact edge. An off-by-one counter drops the grant one cycle early or late. It also applies retry and a stalled master while the lock is held; an arbiter that honoured either would steal a locked bus.

Long random runs in each policy, with a behavioural reference, expose a rotation pointer that is updated on the wrong event or a ping-pong turn that fails to alternate. These runs would show up as a wrong winner after a few grants.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

    localparam int NREQ = 4;

    typedef logic [1:0] mid_t;

    typedef enum logic [1:0] {
        POL_FIXED    = 2'b00,
        POL_ROTATE   = 2'b01,
        POL_HYBRID   = 2'b10,
        POL_PINGPONG = 2'b11
    } policy_e;

    typedef struct packed {
        logic valid;
        mid_t idx;
    } pick_t;

    // Circular scan over all four requesters, starting at 'start'.
    function automatic pick_t scan_from(logic [NREQ-1:0] e, mid_t start);
        pick_t r;
        mid_t  i;
        r = '0;
        for (int k = 0; k < NREQ; k++) begin
            i = start + mid_t'(k);
            if (e[i] && !r.valid) begin
                r.valid = 1'b1;
                r.idx   = i;
            end
        end
        return r;
    endfunction

    // Round-robin over the external requesters 1..3, after 'lastx'.
    function automatic pick_t ext_rr(logic [NREQ-1:0] e, mid_t lastx);
        pick_t r;
        mid_t  i;
        int    j;
        r = '0;
        for (int k = 1; k <= 3; k++) begin
            j = (int'(lastx) - 1 + k) % 3;
            i = mid_t'(j + 1);
            if (e[i] && !r.valid) begin
                r.valid = 1'b1;
                r.idx   = i;
            end
        end
        return r;
    endfunction

    function automatic mid_t pick_target(logic [NREQ-1:0] e, policy_e pol,
                                         mid_t last, mid_t lastx);
        pick_t r;
        pick_t rx;
        pick_t rc;
        rx = ext_rr(e, lastx);
        rc = '{valid: e[0], idx: 2'd0};
        case (pol)
            POL_FIXED:  r = scan_from(e, 2'd0);
            POL_ROTATE: r = scan_from(e, last + 2'd1);
            POL_HYBRID: r = rc.valid ? rc : rx;
            default: begin
                if (last != 2'd0) r = rc.valid ? rc : rx;
                else              r = rx.valid ? rx : rc;
            end
        endcase
        return r.valid ? r.idx : 2'd0;
    endfunction

endpackage

// File: rtl/pci_arb_select.sv
module pci_arb_select
    import pci_arb_pkg::*;
(
    input  logic [NREQ-1:0] elig_i,
    input  policy_e         pol_i,
    input  mid_t            last_i,
    input  mid_t            last_ext_i,
    output mid_t            tgt_o
);
    always_comb tgt_o = pick_target(elig_i, pol_i, last_i, last_ext_i);
endmodule

// File: rtl/pci_arb_mask.sv
module pci_arb_mask
    import pci_arb_pkg::*;
#(
    parameter int RETRY_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] load_i,
    output logic [NREQ-1:0] masked_o
);
    localparam int CW = $clog2(RETRY_CYCLES + 1);

    for (genvar g = 0; g < NREQ; g++) begin : g_cnt
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)                cnt_q <= '0;
            else if (load_i[g])     cnt_q <= CW'(RETRY_CYCLES);
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
        assign masked_o[g] = (cnt_q != '0);
    end
endmodule

// File: rtl/pci_arb_dead.sv
module pci_arb_dead #(
    parameter int DEAD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expire_o
);
    localparam int DW = $clog2(DEAD_CYCLES + 1);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && (cnt_q == DW'(DEAD_CYCLES - 1));
endmodule

// File: rtl/pci_bus_arbiter.sv
module pci_bus_arbiter
    import pci_arb_pkg::*;
#(
    parameter int RETRY_CYCLES = 16,
    parameter int DEAD_CYCLES  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic [3:0] req_i,
    input  logic       idle_i,
    input  logic       lock_i,
    input  logic       retry_i,
    output logic [3:0] gnt_o
);
    logic [NREQ-1:0] gnt_q, gnt_d;
    logic [NREQ-1:0] masked, mask_ld, elig;
    mid_t            last_q, last_ext_q, tgt, own_idx;
    logic            holding, upd, dead_run, dead_exp;

    assign holding = |gnt_q;
    assign elig    = req_i & ~masked;

    always_comb begin
        own_idx = 2'd0;
        for (int i = 0; i < NREQ; i++)
            if (gnt_q[i]) own_idx = mid_t'(i);
    end

    assign dead_run = holding && idle_i && req_i[own_idx] && !lock_i;

    pci_arb_select u_sel (
        .elig_i     (elig),
        .pol_i      (policy_e'(mode_i)),
        .last_i     (last_q),
        .last_ext_i (last_ext_q),
        .tgt_o      (tgt)
    );

    pci_arb_mask #(.RETRY_CYCLES(RETRY_CYCLES)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .load_i   (mask_ld),
        .masked_o (masked)
    );

    pci_arb_dead #(.DEAD_CYCLES(DEAD_CYCLES)) u_dead (
        .clk      (clk),
        .rst      (rst),
        .run_i    (dead_run),
        .expire_o (dead_exp)
    );

    always_comb begin
        gnt_d   = gnt_q;
        mask_ld = '0;
        upd     = 1'b0;
        if (!holding) begin
            gnt_d = NREQ'(1) << tgt;
            upd   = 1'b1;
        end else if (!lock_i) begin
            if (retry_i || dead_exp) begin
                gnt_d            = '0;
                mask_ld[own_idx] = 1'b1;
            end else if (idle_i && tgt != own_idx) begin
                gnt_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q      <= '0;
            last_q     <= 2'd3;
            last_ext_q <= 2'd3;
        end else begin
            gnt_q <= gnt_d;
            if (upd) begin
                last_q <= tgt;
                if (tgt != 2'd0) last_ext_q <= tgt;
            end
        end
    end

    assign gnt_o = gnt_q;
endmodule

// File: rtl/pci_arb_checker.sv
module pci_arb_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] req_i,
    input logic       idle_i,
    input logic       lock_i,
    input logic       retry_i,
    input logic [3:0] gnt_o
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o)); // R1

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != 4'b0000) |=> (gnt_o == 4'b0000 || $stable(gnt_o))); // R6

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != 4'b0000 && !idle_i && !retry_i) |=> $stable(gnt_o)); // R6

    AST_PARK_CPU: assert property (@(posedge clk) disable iff (rst)
        (gnt_o == 4'b0000 && req_i == 4'b0000) |=> gnt_o == 4'b0001); // R7

    AST_RETRY_DROP: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != 4'b0000 && retry_i && !lock_i) |=> gnt_o == 4'b0000); // R8

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != 4'b0000 && lock_i) |=> $stable(gnt_o)); // R10
endmodule

bind pci_bus_arbiter pci_arb_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .idle_i  (idle_i),
    .lock_i  (lock_i),
    .retry_i (retry_i),
    .gnt_o   (gnt_o)
);

// File: tb/tb_pci_bus_arbiter.sv
module tb_pci_bus_arbiter;
    localparam int RC = 5;
    localparam int DC = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic [3:0] req_i = 4'b0000;
    logic       idle_i = 1'b1;
    logic       lock_i = 1'b0;
    logic       retry_i = 1'b0;
    logic [3:0] gnt_o;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    always #2 clk = ~clk;

    pci_bus_arbiter #(.RETRY_CYCLES(RC), .DEAD_CYCLES(DC)) dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .req_i(req_i),
        .idle_i(idle_i), .lock_i(lock_i), .retry_i(retry_i), .gnt_o(gnt_o)
    );

    // ---------------- behavioural reference ----------------
    int m_own = -1, m_last = 3, m_lastx = 3, m_dead = 0;
    int m_mask [4] = '{0, 0, 0, 0};

    function automatic int ext_order(int lastx, int k);
        return 1 + ((lastx - 1 + k) % 3);
    endfunction

    function automatic int choose(bit [3:0] e, int mode, int last, int lastx);
        int order [$];
        case (mode)
            0: order = '{0, 1, 2, 3};
            1: for (int k = 1; k <= 4; k++) order.push_back((last + k) % 4);
            2: begin
                order.push_back(0);
                for (int k = 1; k <= 3; k++) order.push_back(ext_order(lastx, k));
            end
            default: begin
                if (last != 0) order.push_back(0);
                for (int k = 1; k <= 3; k++) order.push_back(ext_order(lastx, k));
                if (last == 0) order.push_back(0);
            end
        endcase
        foreach (order[n]) if (e[order[n]]) return order[n];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_own = -1; m_last = 3; m_lastx = 3; m_dead = 0;
            for (int i = 0; i < 4; i++) m_mask[i] = 0;
        end else begin
            bit [3:0] e;
            int  t;
            bit  run, fire;
            for (int i = 0; i < 4; i++) e[i] = req_i[i] && (m_mask[i] == 0);
            t    = choose(e, int'(mode_i), m_last, m_lastx);
            run  = (m_own >= 0) && idle_i && req_i[m_own] && !lock_i;
            fire = run && (m_dead == DC - 1);
            for (int i = 0; i < 4; i++) if (m_mask[i] > 0) m_mask[i]--;
            if (m_own < 0) begin
                m_own = t; m_last = t;
                if (t != 0) m_lastx = t;
            end else if (!lock_i) begin
                if (retry_i || fire) begin
                    m_mask[m_own] = RC;
                    m_own = -1;
                end else if (idle_i && t != m_own) begin
                    m_own = -1;
                end
            end
            m_dead = run ? m_dead + 1 : 0;
        end
    end

    function automatic logic [3:0] model_gnt();
        return (m_own < 0) ? 4'b0000 : 4'(1 << m_own);
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (gnt_o !== model_gnt()) begin
                errors++;
                $display("FAIL %s model compare: actual=%b expected=%b", phase, gnt_o, model_gnt());
            end
            checks++;
            if ($countones(gnt_o) > 1) begin
                errors++;
                $display("FAIL R1 onehot: actual=%b expected=at most one bit", gnt_o);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic cyc(input logic [3:0] rq, input logic idl, input logic lk, input logic rt);
        req_i = rq; idle_i = idl; lock_i = lk; retry_i = rt;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_gnt(input logic [3:0] exp, input string tag);
        checks++;
        if (gnt_o !== exp) begin
            errors++;
            $display("FAIL %s directed: actual=%b expected=%b", tag, gnt_o, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) begin
            @(negedge clk);
            expect_gnt(4'b0000, "R1");
        end
        rst = 1'b0;
        phase = "R2";
        mode_i = 2'b00;
        cyc(4'b0000, 1, 0, 0); expect_gnt(4'b0001, "R7");
        cyc(4'b1110, 1, 0, 0); expect_gnt(4'b0000, "R6");
        cyc(4'b1110, 1, 0, 0); expect_gnt(4'b0010, "R2");
        cyc(4'b1110, 0, 0, 0); expect_gnt(4'b0010, "R6");
        cyc(4'b1111, 0, 0, 0); expect_gnt(4'b0010, "R6");
        cyc(4'b1111, 1, 0, 0); expect_gnt(4'b0000, "R2");
        cyc(4'b1111, 1, 0, 0); expect_gnt(4'b0001, "R2");
        // retry on the processor
        cyc(4'b1111, 0, 0, 1); expect_gnt(4'b0000, "R8");
        cyc(4'b1111, 1, 0, 0); expect_gnt(4'b0010, "R8");
        // master 0 never starts: dead timer
        for (int k = 1; k < DC; k++) begin
            cyc(4'b1110, 1, 0, 0); expect_gnt(4'b0010, "R9");
        end
        cyc(4'b1110, 1, 0, 0); expect_gnt(4'b0000, "R9");
        cyc(4'b1110, 1, 0, 0); expect_gnt(4'b0100, "R9");
        // lock holds master 1 against retry, dead timer and priority
        for (int k = 0; k < 10; k++) begin
            cyc(4'b1111, 1, 1, (k == 3) ? 1'b1 : 1'b0);
            expect_gnt(4'b0100, "R10");
        end
        cyc(4'b1111, 1, 0, 0); expect_gnt(4'b0000, "R6");
        cyc(4'b1111, 1, 0, 0); expect_gnt(4'b0001, "R2");

        // random phases, one per policy
        for (int m = 0; m < 4; m++) begin
            mode_i = 2'(m);
            case (m)
                0: phase = "R2";
                1: phase = "R3";
                2: phase = "R4";
                default: phase = "R5";
            endcase
            for (int n = 0; n < 3000; n++) begin
                logic [3:0] rq;
                rq = ($urandom_range(0, 9) == 0) ? 4'b0000 : 4'($urandom);
                cyc(rq, ($urandom_range(0, 9) < 7),
                    ($urandom_range(0, 19) == 0),
                    ($urandom_range(0, 29) == 0));
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule